// File: doc/BRIEF.md
# Page ECC Status Checker

This block decides the fate of a flash page that has just been read into one of the controller's page buffers. After a `start` pulse it polls an event status word until the operation-complete flag appears. It reports a fatal result when the flash-timeout flag is also set. Otherwise it walks the per-sector error counts of that page, which are packed four to a 32-bit word in a small bank of status words. The result is one of three outcomes: the page is usable (`res_ok`), the page is erased (`res_blank`), or it is unrecoverable (`res_fatal`).

A count of 0xF marks a sector that the ECC engine could not correct. An erased page fails the ECC check in the same way, so the block then scans the page contents, supplied as a byte stream with a valid/ready handshake. If every byte of the page is 0xFF, the failure is excused and the page is reported blank. The scan stops at the first byte that is not 0xFF, and that page is fatal. When it finishes, the block writes the status word it observed back to the event register, which clears the write-one-to-clear flags. In the same cycle it raises `done` for one cycle.

The controller is a five-state machine:
- **IDLE** goes to **POLL** on `start`.
- **POLL** stays put until the operation-complete flag is seen. It then goes to **CLEAR** on a timeout, or to **SECT** otherwise.
- **SECT** examines one sector per cycle. It goes to **SCAN** on an uncorrectable count, to **CLEAR** after the last sector of the page, and otherwise stays in **SECT** on the next sector.
- **SCAN** consumes one byte per accepted beat. It goes to **CLEAR** on a non-0xFF byte or after the last byte of the page.
- **CLEAR** writes back, pulses `done` and returns to **IDLE**.

Top module: `page_ecc_judge`

## Requirements
- R1: After reset, `busy`, `done`, `evt_wr_en`, `byte_ready`, `res_ok`, `res_blank` and `res_fatal` are all 0.
- R2: After `start`, while bit 0 of `evt_stat` (operation complete) is 0, the block stays busy, does not raise `done` and does not write back.
- R3: When operation complete is seen together with bit 1 of `evt_stat` (flash timeout), the result is fatal (`res_fatal`=1, others 0), and no page byte is consumed.
- R4: `page_mode` 0 means a 512-byte page (1 sector), 1 means 2048 bytes (4 sectors), and 2 or 3 mean 4096 bytes (8 sectors). The sectors checked run from (`buf_idx` × sectors per page) mod 16 up to that value plus sectors per page minus 1, so `buf_idx` is effectively masked to 4, 2 or 1 bits.
- R5: The count of sector n is bits [(3 − n mod 4)×8 +: 4] of status word n/4, read through `ecc_addr`/`ecc_rdata`. The upper nibble of each byte lane is ignored.
- R6: If no sector of the page has count 0xF, the result is ok. Counts of sectors outside the page have no effect.
- R7: At the first sector with count 0xF, the page bytes are scanned. If all page bytes are 0xFF, the result is blank, exactly page-size bytes are consumed, and no further sector is examined.
- R8: If the scan meets a byte other than 0xFF, the result is fatal and the scan stops after consuming that byte.
- R9: On completion, `evt_wr_en` and `done` are high together for exactly one cycle, with `evt_wr_data` equal to the `evt_stat` value sampled when operation complete was seen.
- R10: Exactly one result flag is set at `done`. The result flags are cleared by `start` and hold unchanged from `done` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin judging a page (accepted when idle) |
| page_mode | input | 2 | Page size code: 0 = 512 B, 1 = 2 KiB, 2/3 = 4 KiB |
| buf_idx | input | 4 | Page buffer number |
| busy | output | 1 | Block is between start and done |
| done | output | 1 | One-cycle completion pulse |
| evt_stat | input | 32 | Event status word; bit 0 operation complete, bit 1 flash timeout |
| evt_wr_en | output | 1 | Write strobe for clearing the event register |
| evt_wr_data | output | 32 | Value written back (the observed status) |
| ecc_addr | output | 2 | Status word index into the error-count bank |
| ecc_rdata | input | 32 | Addressed status word (combinational read) |
| byte_valid | input | 1 | Page byte stream valid |
| byte_data | input | 8 | Page byte stream data |
| byte_ready | output | 1 | Block accepts a page byte this cycle |
| res_ok | output | 1 | Page good or correctable |
| res_blank | output | 1 | Page erased |
| res_fatal | output | 1 | Timeout or uncorrectable data |

## Verification
The embedded properties watch the cycle-level rules on every clock:
- the single-cycle completion and write-back pulse, and that the written value carries the operation-complete flag;
- exactly one result flag at completion, and results holding while idle;
- the timeout path to fatal;
- that the byte stream is never requested unless an uncorrectable count was just seen;
- that a non-0xFF byte ends the scan as fatal.

Only the bench scenarios can show the rest, because those need known data and a reference. They cover which word and lane hold each sector's count under every page mode, the masking of the buffer number, that counts outside the page are ignored, the exact number of bytes consumed by a blank or failing scan, and that the scan stops at the page end.

// File: rtl/pecc_pkg.sv
package pecc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_SECT,
        ST_SCAN,
        ST_CLEAR
    } pecc_state_e;

    localparam logic [1:0] MODE_SMALL = 2'd0;
    localparam logic [1:0] MODE_MID   = 2'd1;

    localparam int MAX_SECT_PER_PAGE = 8;

endpackage

// File: rtl/pecc_geometry.sv
module pecc_geometry #(
    parameter int SECT_BYTES = 512,
    parameter int SECT_W     = 4,
    parameter int BYTE_W     = 12
) (
    input  logic [1:0]        page_mode,
    input  logic [SECT_W-1:0] buf_idx,
    output logic [SECT_W-1:0] first_sect,
    output logic [SECT_W-1:0] last_sect,
    output logic [BYTE_W-1:0] last_byte
);
    import pecc_pkg::*;

    logic [SECT_W-1:0] span_m1;
    logic [1:0]        shift;

    always_comb begin
        unique case (page_mode)
            MODE_SMALL: begin
                shift     = 2'd0;
                span_m1   = SECT_W'(0);
                last_byte = BYTE_W'(SECT_BYTES - 1);
            end
            MODE_MID: begin
                shift     = 2'd2;
                span_m1   = SECT_W'(3);
                last_byte = BYTE_W'(4 * SECT_BYTES - 1);
            end
            default: begin
                shift     = 2'd3;
                span_m1   = SECT_W'(MAX_SECT_PER_PAGE - 1);
                last_byte = BYTE_W'(MAX_SECT_PER_PAGE * SECT_BYTES - 1);
            end
        endcase
    end

    // Shifting within SECT_W bits drops the high buffer bits (buffer wrap).
    assign first_sect = buf_idx << shift;
    assign last_sect  = first_sect + span_m1;

endmodule

// File: rtl/pecc_lane_pick.sv
module pecc_lane_pick #(
    parameter int NUM_WORDS = 4,
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8,
    parameter int CNT_BITS  = 4,
    parameter int SECT_W    = 4,
    parameter int ADDR_W    = 2
) (
    input  logic [SECT_W-1:0]          sect,
    input  logic [LANES*LANE_BITS-1:0] rdata,
    output logic [ADDR_W-1:0]          word_addr,
    output logic [CNT_BITS-1:0]        count,
    output logic                       uncorr
);
    localparam int LSEL_W = $clog2(LANES);

    logic [CNT_BITS-1:0] lane_cnt [LANES];
    logic [LSEL_W-1:0]   lane_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_cnt[g] = rdata[g*LANE_BITS +: CNT_BITS];
    end

    // Lowest-numbered sector of a word sits in the most significant lane.
    assign lane_sel  = LSEL_W'(LANES - 1) - sect[LSEL_W-1:0];
    assign word_addr = ADDR_W'(sect >> LSEL_W);
    assign count     = lane_cnt[lane_sel];
    assign uncorr    = &count;

endmodule

// File: rtl/page_ecc_judge.sv
module page_ecc_judge #(
    parameter int NUM_WORDS  = 4,
    parameter int SECT_BYTES = 512,
    parameter int OPC_BIT    = 0,
    parameter int TMO_BIT    = 1,
    localparam int LANES     = 4,
    localparam int WORD_W    = 32,
    localparam int SECT_W    = $clog2(NUM_WORDS * LANES),
    localparam int ADDR_W    = $clog2(NUM_WORDS),
    localparam int BYTE_W    = $clog2(pecc_pkg::MAX_SECT_PER_PAGE * SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        page_mode,
    input  logic [SECT_W-1:0] buf_idx,
    output logic              busy,
    output logic              done,
    input  logic [WORD_W-1:0] evt_stat,
    output logic              evt_wr_en,
    output logic [WORD_W-1:0] evt_wr_data,
    output logic [ADDR_W-1:0] ecc_addr,
    input  logic [WORD_W-1:0] ecc_rdata,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              res_ok,
    output logic              res_blank,
    output logic              res_fatal
);
    import pecc_pkg::*;

    pecc_state_e       state, nxt;
    logic [1:0]        mode_q;
    logic [SECT_W-1:0] buf_q;
    logic [WORD_W-1:0] stat_q;
    logic [SECT_W-1:0] sect_q;
    logic [BYTE_W-1:0] bcnt_q;
    logic              ok_q, blank_q, fatal_q;

    logic [SECT_W-1:0] first_sect, last_sect;
    logic [BYTE_W-1:0] last_byte;
    logic [3:0]        sect_cnt;
    logic              uncorr;

    pecc_geometry #(
        .SECT_BYTES (SECT_BYTES),
        .SECT_W     (SECT_W),
        .BYTE_W     (BYTE_W)
    ) u_geom (
        .page_mode  (mode_q),
        .buf_idx    (buf_q),
        .first_sect (first_sect),
        .last_sect  (last_sect),
        .last_byte  (last_byte)
    );

    pecc_lane_pick #(
        .NUM_WORDS (NUM_WORDS),
        .LANES     (LANES),
        .LANE_BITS (WORD_W / LANES),
        .CNT_BITS  (4),
        .SECT_W    (SECT_W),
        .ADDR_W    (ADDR_W)
    ) u_pick (
        .sect      (sect_q),
        .rdata     (ecc_rdata),
        .word_addr (ecc_addr),
        .count     (sect_cnt),
        .uncorr    (uncorr)
    );

    wire opc_seen  = evt_stat[OPC_BIT];
    wire tmo_seen  = evt_stat[TMO_BIT];
    wire byte_bad  = (byte_data != 8'hFF);
    wire page_end  = (bcnt_q == last_byte);
    wire sect_last = (sect_q == last_sect);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_POLL;
            ST_POLL:  if (opc_seen) nxt = tmo_seen ? ST_CLEAR : ST_SECT;
            ST_SECT: begin
                if (uncorr)         nxt = ST_SCAN;
                else if (sect_last) nxt = ST_CLEAR;
            end
            ST_SCAN:  if (byte_valid && (byte_bad || page_end)) nxt = ST_CLEAR;
            ST_CLEAR: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Working registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            buf_q   <= '0;
            stat_q  <= '0;
            sect_q  <= '0;
            bcnt_q  <= '0;
            ok_q    <= 1'b0;
            blank_q <= 1'b0;
            fatal_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q  <= page_mode;
                    buf_q   <= buf_idx;
                    ok_q    <= 1'b0;
                    blank_q <= 1'b0;
                    fatal_q <= 1'b0;
                end
                ST_POLL: if (opc_seen) begin
                    stat_q <= evt_stat;
                    sect_q <= first_sect;
                    if (tmo_seen) fatal_q <= 1'b1;
                end
                ST_SECT: begin
                    if (uncorr)         bcnt_q <= '0;
                    else if (sect_last) ok_q   <= 1'b1;
                    else                sect_q <= sect_q + 1'b1;
                end
                ST_SCAN: if (byte_valid) begin
                    if (byte_bad)      fatal_q <= 1'b1;
                    else if (page_end) blank_q <= 1'b1;
                    else               bcnt_q  <= bcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_CLEAR);
        evt_wr_en   = (state == ST_CLEAR);
        evt_wr_data = stat_q;
        byte_ready  = (state == ST_SCAN);
        res_ok      = ok_q;
        res_blank   = blank_q;
        res_fatal   = fatal_q;
    end

    // Assertions
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");

    assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr_en |-> (done && evt_wr_data[OPC_BIT])) else $error("bad write-back");

    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({res_ok, res_blank, res_fatal}) == 1)) else $error("result not one-hot");

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable({res_ok, res_blank, res_fatal}))
        else $error("result changed while idle");

    assert_timeout_fatal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && opc_seen && tmo_seen) |=> (done && res_fatal))
        else $error("timeout not fatal");

    assert_no_scan_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECT && !uncorr) |=> !byte_ready) else $error("scan without uncorrectable");

    assert_bad_byte_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && byte_valid && byte_bad) |=> (!byte_ready && res_fatal))
        else $error("scan continued past bad byte");

endmodule

// File: tb/page_ecc_judge_test.sv
module page_ecc_judge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  page_mode = 2'd0;
    logic [3:0]  buf_idx = 4'd0;
    logic        busy, done, evt_wr_en, byte_ready;
    logic [31:0] evt_stat = 32'd0;
    logic [31:0] evt_wr_data;
    logic [1:0]  ecc_addr;
    logic [31:0] ecc_rdata;
    logic        byte_valid = 1'b1;
    logic [7:0]  byte_data;
    logic        res_ok, res_blank, res_fatal;

    logic [31:0] bank [4];
    logic [7:0]  page_mem [4096];
    logic [12:0] byte_ptr;
    logic        ptr_clr = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        ok, blank, fatal;
        logic [31:0] wr;
        int          used;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    assign ecc_rdata = bank[ecc_addr];
    assign byte_data = page_mem[byte_ptr[11:0]];

    always_ff @(posedge clk) begin
        if (ptr_clr)                       byte_ptr <= '0;
        else if (byte_ready && byte_valid) byte_ptr <= byte_ptr + 1'b1;
    end

    page_ecc_judge uut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
        .buf_idx(buf_idx), .busy(busy), .done(done), .evt_stat(evt_stat),
        .evt_wr_en(evt_wr_en), .evt_wr_data(evt_wr_data), .ecc_addr(ecc_addr),
        .ecc_rdata(ecc_rdata), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .res_ok(res_ok), .res_blank(res_blank),
        .res_fatal(res_fatal)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic fill_page(input int bad_at, input logic [7:0] bad_val);
        for (int i = 0; i < 4096; i++) page_mem[i] = 8'hFF;
        if (bad_at >= 0) page_mem[bad_at] = bad_val;
    endtask

    task automatic set_bank(input logic [31:0] w0, w1, w2, w3);
        bank[0] = w0; bank[1] = w1; bank[2] = w2; bank[3] = w3;
    endtask

    // Driver: pushes the expectation, then runs one judgement
    task automatic run_case(input logic [1:0] mode, input logic [3:0] b,
                            input logic [31:0] evt, input int wait_cyc,
                            input logic e_ok, e_blank, e_fatal,
                            input int e_used, input string tag);
        exp_t e;
        logic [2:0] held;
        e.ok = e_ok; e.blank = e_blank; e.fatal = e_fatal;
        e.wr = evt; e.used = e_used; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        ptr_clr = 1'b1; page_mode = mode; buf_idx = b; start = 1'b1;
        @(negedge clk);
        ptr_clr = 1'b0; start = 1'b0;
        for (int k = 0; k < wait_cyc; k++) begin
            chk({tag, " R2 busy while polling"}, busy, 1);
            chk({tag, " R2 no done/writeback while polling"}, {done, evt_wr_en}, 0);
            chk({tag, " R10 results cleared by start"}, {res_ok, res_blank, res_fatal}, 0);
            @(negedge clk);
        end
        evt_stat = evt;
        while (!done) @(negedge clk);
        @(negedge clk);
        evt_stat = 32'd0;
        held = {res_ok, res_blank, res_fatal};
        repeat (3) @(negedge clk);
        chk({tag, " R10 results held after done"}, {res_ok, res_blank, res_fatal}, held);
        chk({tag, " R9 single done pulse"}, done, 0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " result ok/blank/fatal"}, {res_ok, res_blank, res_fatal},
                    {e.ok, e.blank, e.fatal});
                chk({e.tag, " R9 write-back strobe"}, evt_wr_en, 1);
                chk({e.tag, " R9 write-back value"}, evt_wr_data, e.wr);
                chk({e.tag, " bytes consumed"}, byte_ptr, e.used);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_bank(0, 0, 0, 0);
        fill_page(-1, 8'h00);
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {busy, done, evt_wr_en, byte_ready, res_ok, res_blank, res_fatal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done, evt_wr_en, byte_ready}, 0);

        // R6: max correctable counts on 2K page in buffer 1 (sectors 4..7)
        set_bank(0, 32'h0E0E_0E0E, 0, 0);
        run_case(2'd1, 4'd1, 32'h0000_0101, 5, 1, 0, 0, 0, "R6 R9 correctable");

        // R5 R6: upper nibbles set, other page all 0xF
        set_bank(32'hF0F0_F0F0, 32'h0F0F_0F0F, 0, 0);
        run_case(2'd1, 4'd0, 32'h1, 2, 1, 0, 0, 0, "R5 R6 lanes ignored");

        // R4 R8: buffer 5 masks to 1; sector 7 (word1 bits 3:0) bad, byte 100 non-FF
        set_bank(0, 32'h0000_000F, 0, 0);
        fill_page(100, 8'h00);
        run_case(2'd1, 4'd5, 32'h1, 2, 0, 0, 1, 101, "R4 R8 masked buffer fatal");

        // R7: 4K buffer 1 (sectors 8..15), sector 9 bad, page erased
        set_bank(0, 0, 32'h000F_0000, 32'h0F00_0000);
        fill_page(-1, 8'h00);
        run_case(2'd2, 4'd1, 32'h1, 2, 0, 1, 0, 4096, "R7 erased 4K");

        // R4 R8: 512-byte buffer 13 (word3 bits 19:16), last byte bad
        set_bank(0, 0, 0, 32'h000F_0000);
        fill_page(511, 8'hFE);
        run_case(2'd0, 4'd13, 32'h1, 2, 0, 0, 1, 512, "R4 R8 last byte bad");

        // R7: same page erased; byte beyond the page is not FF
        fill_page(512, 8'h00);
        run_case(2'd0, 4'd13, 32'h1, 2, 0, 1, 0, 512, "R7 scan ends at page end");

        // R3: timeout with uncorrectable counts present
        set_bank(32'h0F0F_0F0F, 0, 0, 0);
        run_case(2'd1, 4'd0, 32'h3, 3, 0, 0, 1, 0, "R3 timeout");

        // R4: mode 3 acts as 4K, sector 3 bad, erased
        set_bank(32'h0000_000F, 0, 0, 0);
        fill_page(-1, 8'h00);
        run_case(2'd3, 4'd0, 32'h1, 2, 0, 1, 0, 4096, "R4 mode3 as 4K");

        // R4 R5: 512-byte buffer 2 is word0 bits 15:8; neighbours bad
        set_bank(32'h0F00_000F, 0, 0, 0);
        fill_page(0, 8'h00);
        run_case(2'd0, 4'd2, 32'h1, 2, 1, 0, 0, 0, "R4 R5 single sector lane");

        repeat (4) @(negedge clk);
        chk("R9 all completions seen", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule